// File: doc/BRIEF.md
# Flash Sector Write-Protect Tracker

This block holds the write-protection state of a 39-sector flash array addressed by 20-bit word addresses. The sector layout is not uniform. It has eight 4K-word small sectors and thirty-one 32K-word large sectors. The small sectors sit either at the top or at the bottom of the address space, and a parameter selects which. Each sector carries two state bits: a lock bit and a sticky lock-down bit.

A command decoder in front of this block sends it one protection request per cycle, each carrying a sector address. It also passes through the level of the active-low write-protect pin. Before starting a program or erase, the decoder asks whether that address may be altered. It gets back either a grant or a lock-violation flag for its status logic. For configuration reads, the decoder can also fetch the two-bit protection code of any sector.

Top module: `sector_guard`

## Requirements
- R1: After a synchronous reset, every sector reads back code 01: locked and not locked down.
- R2: With TOP_BOOT=1, addresses F8000h to FFFFFh form eight 4K-word sectors, and 00000h to F7FFFh form thirty-one 32K-word sectors aligned on 8000h.
- R3: With TOP_BOOT=0, addresses 00000h to 07FFFh form eight 4K-word sectors, and the 32K-word sectors start at 08000h.
- R4: A request with req_op=00 (lock) sets the lock bit of the addressed sector only. A request with req_op=11 has no effect.
- R5: A request with req_op=01 (unlock) while wp_n=1 clears the lock bit of every sector at once.
- R6: A request with req_op=10 (lock-down) sets both the lock bit and the lock-down bit of the addressed sector.
- R7: An unlock while wp_n=0 clears the lock bits of all sectors except those that are locked down.
- R8: Only reset clears a lock-down bit. An unlock with wp_n=1 clears its lock bit but leaves the lock-down bit set.
- R9: One cycle after chk_valid, exactly one of chk_ok and chk_err is high. In the cycle after a cycle without chk_valid, both are low.
- R10: A check is refused (chk_err) when the sector is locked, or when it is locked down and wp_n=0. Otherwise it is granted (chk_ok).
- R11: One cycle after cfg_addr is presented, cfg_code gives the addressed sector's state. Bit 0 is the lock bit and bit 1 is the lock-down bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin level, low protects |
| req_valid | input | 1 | Protection request strobe |
| req_op | input | 2 | 00 lock, 01 unlock, 10 lock-down, 11 none |
| req_addr | input | 20 | Word address inside the target sector |
| chk_valid | input | 1 | Program/erase permission query strobe |
| chk_addr | input | 20 | Word address to be altered |
| chk_ok | output | 1 | Registered grant |
| chk_err | output | 1 | Registered lock-violation flag |
| cfg_addr | input | 20 | Address for the protection code read |
| cfg_code | output | 2 | Registered protection code |

## Verification
A protection request changes state at the clock edge that samples it, so it is first visible to a query made in the following cycle. The answers on chk_ok, chk_err and cfg_code are registered and are due at the same edge that samples the query. The bench drives each stimulus just after a falling edge. It reads the answer 1 ns after the next rising edge, before the next stimulus is driven. Each step therefore takes one cycle, and any request lands before the query after it.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    OP_LOCK     = 2'b00,
    OP_UNLOCK   = 2'b01,
    OP_LOCKDOWN = 2'b10,
    OP_NONE     = 2'b11
  } prot_op_e;
endpackage

// File: rtl/sg_sector_map.sv
module sg_sector_map #(
  parameter int ADDR_W   = 20,
  parameter int SMALL_W  = 12,
  parameter int MAIN_W   = 15,
  parameter bit TOP_BOOT = 1'b1,
  parameter int IDX_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int HI_W      = ADDR_W - MAIN_W;
  localparam int SUB_W     = MAIN_W - SMALL_W;
  localparam int NUM_SMALL = 1 << SUB_W;
  localparam int NUM_HI    = 1 << HI_W;

  logic [HI_W-1:0]  hi;
  logic [SUB_W-1:0] sub;
  assign hi  = addr[ADDR_W-1:MAIN_W];
  assign sub = addr[MAIN_W-1:SMALL_W];

  generate
    if (TOP_BOOT) begin : g_top
      // Small sectors fill the last large slot; large sectors are numbered by slot.
      always_comb begin
        if (hi == HI_W'(NUM_HI - 1)) idx = IDX_W'(NUM_HI - 1) + IDX_W'(sub);
        else                         idx = IDX_W'(hi);
      end
    end else begin : g_bottom
      // Small sectors fill slot 0; large sectors follow them.
      always_comb begin
        if (hi == '0) idx = IDX_W'(sub);
        else          idx = IDX_W'(hi) + IDX_W'(NUM_SMALL - 1);
      end
    end
  endgenerate
endmodule

// File: rtl/sg_lock_bank.sv
module sg_lock_bank
  import sg_pkg::*;
#(
  parameter int NUM_SECT = 39,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          op,
  input  logic [IDX_W-1:0]    idx,
  input  logic                wp_n,
  output logic [NUM_SECT-1:0] lock_q,
  output logic [NUM_SECT-1:0] down_q
);
  prot_op_e op_e;
  assign op_e = prot_op_e'(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '1;
      down_q <= '0;
    end else if (wr_en) begin
      if (op_e == OP_UNLOCK) begin
        lock_q <= wp_n ? '0 : (lock_q & down_q);
      end else begin
        for (int i = 0; i < NUM_SECT; i++) begin
          if (idx == IDX_W'(i)) begin
            if (op_e == OP_LOCK || op_e == OP_LOCKDOWN) lock_q[i] <= 1'b1;
            if (op_e == OP_LOCKDOWN)                    down_q[i] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sg_access_judge.sv
module sg_access_judge #(
  parameter int NUM_SECT = 39,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                chk_valid,
  input  logic [IDX_W-1:0]    chk_idx,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                wp_n,
  input  logic [NUM_SECT-1:0] lock_q,
  input  logic [NUM_SECT-1:0] down_q,
  output logic                chk_ok,
  output logic                chk_err,
  output logic [1:0]          cfg_code
);
  logic refused;
  assign refused = lock_q[chk_idx] | (down_q[chk_idx] & ~wp_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_ok   <= 1'b0;
      chk_err  <= 1'b0;
      cfg_code <= 2'b00;
    end else begin
      chk_ok   <= chk_valid & ~refused;
      chk_err  <= chk_valid & refused;
      cfg_code <= {down_q[cfg_idx], lock_q[cfg_idx]};
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W   = 20,
  parameter int SMALL_W  = 12,
  parameter int MAIN_W   = 15,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_ok,
  output logic              chk_err,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic [1:0]        cfg_code
);
  localparam int NUM_SECT = (1 << (ADDR_W - MAIN_W)) - 1 + (1 << (MAIN_W - SMALL_W));
  localparam int IDX_W    = $clog2(NUM_SECT);

  logic [IDX_W-1:0]    req_idx, chk_idx, cfg_idx;
  logic [NUM_SECT-1:0] lock_q, down_q;

  sg_sector_map #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .MAIN_W(MAIN_W),
                  .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    map_req_i (.addr(req_addr), .idx(req_idx));
  sg_sector_map #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .MAIN_W(MAIN_W),
                  .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    map_chk_i (.addr(chk_addr), .idx(chk_idx));
  sg_sector_map #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .MAIN_W(MAIN_W),
                  .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
    map_cfg_i (.addr(cfg_addr), .idx(cfg_idx));

  sg_lock_bank #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) bank_i (
    .clk(clk), .rst(rst), .wr_en(req_valid), .op(req_op), .idx(req_idx),
    .wp_n(wp_n), .lock_q(lock_q), .down_q(down_q));

  sg_access_judge #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) judge_i (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_idx(chk_idx),
    .cfg_idx(cfg_idx), .wp_n(wp_n), .lock_q(lock_q), .down_q(down_q),
    .chk_ok(chk_ok), .chk_err(chk_err), .cfg_code(cfg_code));
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk
  import sg_pkg::*;
#(
  parameter int NUM_SECT = 39
) (
  input logic                clk,
  input logic                rst,
  input logic                wp_n,
  input logic                req_valid,
  input logic [1:0]          req_op,
  input logic                chk_valid,
  input logic                chk_ok,
  input logic                chk_err,
  input logic [NUM_SECT-1:0] lock_q,
  input logic [NUM_SECT-1:0] down_q
);
  logic unlock_req;
  assign unlock_req = req_valid && (req_op == 2'(OP_UNLOCK));

  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (lock_q == '1) && (down_q == '0));

  assert_unlock_all_R5: assert property (@(posedge clk) disable iff (rst)
    unlock_req && wp_n |=> lock_q == '0);

  assert_unlock_keep_down_R7: assert property (@(posedge clk) disable iff (rst)
    unlock_req && !wp_n |=> (lock_q & ~down_q) == '0);

  assert_lockdown_sets_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_op == 2'(OP_LOCKDOWN)) |=> (down_q & lock_q) != '0);

  assert_down_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (down_q & $past(down_q)) == $past(down_q));

  assert_one_answer_R9: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> (chk_ok ^ chk_err));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_ok && !chk_err);
endmodule

bind sector_guard sector_guard_chk #(.NUM_SECT(NUM_SECT)) chk_bind_i (
  .clk(clk), .rst(rst), .wp_n(wp_n), .req_valid(req_valid), .req_op(req_op),
  .chk_valid(chk_valid), .chk_ok(chk_ok), .chk_err(chk_err),
  .lock_q(lock_q), .down_q(down_q));

// File: tb/sector_guard_tb_top.sv
module sector_guard_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        wp_n, req_valid, chk_valid, chk_ok, chk_err;
  logic [1:0]  req_op, cfg_code;
  logic [19:0] req_addr, chk_addr, cfg_addr;

  logic        b_wp_n, b_req_valid, b_chk_valid, b_chk_ok, b_chk_err;
  logic [1:0]  b_req_op, b_cfg_code;
  logic [19:0] b_req_addr, b_chk_addr, b_cfg_addr;

  int checks = 0;
  int failures = 0;

  sector_guard #(.TOP_BOOT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wp_n(wp_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .chk_valid(chk_valid), .chk_addr(chk_addr),
    .chk_ok(chk_ok), .chk_err(chk_err), .cfg_addr(cfg_addr), .cfg_code(cfg_code));

  sector_guard #(.TOP_BOOT(1'b0)) dut_b (
    .clk(clk), .rst(rst), .wp_n(b_wp_n), .req_valid(b_req_valid), .req_op(b_req_op),
    .req_addr(b_req_addr), .chk_valid(b_chk_valid), .chk_addr(b_chk_addr),
    .chk_ok(b_chk_ok), .chk_err(b_chk_err), .cfg_addr(b_cfg_addr), .cfg_code(b_cfg_code));

  // {req tag[30:27], kind[26:25] 0=req 1=check 2=cfg, op[24:23], addr[22:3], wp_n[2], exp[1:0]}
  // check exp = {ok,err}; cfg exp = {down,lock}
  localparam int NV = 24;
  localparam logic [30:0] VECS [NV] = '{
    {4'd10, 2'd1, 2'd0, 20'h00000, 1'b1, 2'b01}, // R10 R1 locked after reset
    {4'd1,  2'd2, 2'd0, 20'hFF000, 1'b1, 2'b01}, // R1
    {4'd5,  2'd0, 2'd1, 20'h00000, 1'b1, 2'b00}, // R5 unlock all
    {4'd5,  2'd1, 2'd0, 20'h00000, 1'b1, 2'b10}, // R5
    {4'd5,  2'd1, 2'd0, 20'hFF000, 1'b1, 2'b10}, // R5
    {4'd4,  2'd0, 2'd0, 20'hF9000, 1'b1, 2'b00}, // R4 lock small sector
    {4'd2,  2'd1, 2'd0, 20'hF9FFF, 1'b1, 2'b01}, // R2 same 4K sector
    {4'd2,  2'd1, 2'd0, 20'hFA000, 1'b1, 2'b10}, // R2 next 4K sector
    {4'd2,  2'd1, 2'd0, 20'hF8FFF, 1'b1, 2'b10}, // R2 previous 4K sector
    {4'd4,  2'd0, 2'd0, 20'h10000, 1'b1, 2'b00}, // R4 lock large sector
    {4'd2,  2'd1, 2'd0, 20'h17FFF, 1'b1, 2'b01}, // R2 32K span
    {4'd2,  2'd1, 2'd0, 20'h18000, 1'b1, 2'b10}, // R2
    {4'd6,  2'd0, 2'd2, 20'h40000, 1'b1, 2'b00}, // R6 lock-down
    {4'd6,  2'd2, 2'd0, 20'h47FFE, 1'b1, 2'b11}, // R6 R11
    {4'd7,  2'd0, 2'd1, 20'h00000, 1'b0, 2'b00}, // R7 unlock, pin low
    {4'd7,  2'd2, 2'd0, 20'h40002, 1'b0, 2'b11}, // R7 still locked
    {4'd7,  2'd2, 2'd0, 20'hF9002, 1'b0, 2'b00}, // R7 others cleared
    {4'd7,  2'd1, 2'd0, 20'h10000, 1'b1, 2'b10}, // R7
    {4'd8,  2'd0, 2'd1, 20'h00000, 1'b1, 2'b00}, // R8 unlock, pin high
    {4'd8,  2'd2, 2'd0, 20'h40002, 1'b1, 2'b10}, // R8 down bit stays
    {4'd10, 2'd1, 2'd0, 20'h40000, 1'b1, 2'b10}, // R10 pin high grants
    {4'd10, 2'd1, 2'd0, 20'h40000, 1'b0, 2'b01}, // R10 pin low refuses
    {4'd10, 2'd1, 2'd0, 20'h48000, 1'b0, 2'b10}, // R10
    {4'd4,  2'd0, 2'd3, 20'h00000, 1'b1, 2'b00}  // R4 op 11 ignored
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; chk_valid = 1'b0;
    b_req_valid = 1'b0; b_chk_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [30:0] v);
    @(negedge clk);
    wp_n = v[2];
    if (v[26:25] == 2'd0) begin req_valid = 1'b1; req_op = v[24:23]; req_addr = v[22:3]; end
    if (v[26:25] == 2'd1) begin chk_valid = 1'b1; chk_addr = v[22:3]; end
    if (v[26:25] == 2'd2) cfg_addr = v[22:3];
    @(posedge clk); #1;
    if (v[26:25] == 2'd1) check($sformatf("R%0d check %h", v[30:27], v[22:3]), {chk_ok, chk_err}, v[1:0]);
    if (v[26:25] == 2'd2) check($sformatf("R%0d cfg %h", v[30:27], v[22:3]), cfg_code, v[1:0]);
    idle_inputs();
  endtask

  task automatic b_step(input int kind, input logic [1:0] op, input logic [19:0] a,
                        input logic [1:0] exp, input string tag);
    @(negedge clk);
    b_wp_n = 1'b1;
    if (kind == 0) begin b_req_valid = 1'b1; b_req_op = op; b_req_addr = a; end
    else begin b_chk_valid = 1'b1; b_chk_addr = a; end
    @(posedge clk); #1;
    if (kind == 1) check(tag, {b_chk_ok, b_chk_err}, exp);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    wp_n = 1'b1; req_op = 2'b11; req_addr = '0; chk_addr = '0; cfg_addr = '0;
    b_wp_n = 1'b1; b_req_op = 2'b11; b_req_addr = '0; b_chk_addr = '0; b_cfg_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // R4: op 11 left sector 00000h unlocked
    run_vec({4'd4, 2'd1, 2'd0, 20'h00000, 1'b1, 2'b10});

    // R9: no query gives no answer
    @(negedge clk); @(posedge clk); #1;
    check("R9 idle", {chk_ok, chk_err}, 2'b00);

    // R3: bottom-boot mirror
    b_step(0, 2'b01, 20'h00000, 2'b00, "R3 unlock");
    b_step(0, 2'b00, 20'h07000, 2'b00, "R3 lock");
    b_step(1, 2'b00, 20'h07FFF, 2'b01, "R3 small top");
    b_step(1, 2'b00, 20'h06FFF, 2'b10, "R3 small neighbour");
    b_step(1, 2'b00, 20'h08000, 2'b10, "R3 first large");
    b_step(0, 2'b00, 20'hF8000, 2'b00, "R3 lock last");
    b_step(1, 2'b00, 20'hFFFFF, 2'b01, "R3 last large");
    b_step(1, 2'b00, 20'hF7FFF, 2'b10, "R3 previous large");

    // R1 R8: reset clears lock-down and relocks
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; cfg_addr = 20'h40000;
    @(posedge clk); #1;
    check("R8 R1 cfg after reset", cfg_code, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule